// File: doc/BRIEF.md
# Segmented Address and Word-Split Unit

This unit connects a 16-bit processor core to a byte-wide memory with a 20-bit physical address space. It holds four segment registers. For each one it keeps the base address already shifted into physical form. It turns a segment choice plus a 16-bit offset into a physical address. It then runs every byte or word access as a series of single-byte memory cycles.

Most words occupy two adjacent bytes. There are two exceptions:
- A word whose offset is 0xFFFF takes its high byte from offset 0 of the same segment.
- A word whose low byte falls at the last physical byte takes its high byte from physical address 0.

Read-modify-write accesses fetch the old value first. The unit then presents that value to the core, waits for the modified value, and writes it back to the same one or two byte addresses.

A request is accepted while the unit is idle. The unit stays busy until it raises a single-cycle done strobe. The memory port is asynchronous for reads: read data must be valid during the same cycle that the unit drives the address.

Top module: `seg_word_mover`

## Requirements
- R1: After reset the CS base is 0xFFFF0 and the ES, SS and DS bases are 0. A word read from CS at offset 0 therefore touches physical 0xFFFF0 first.
- R2: Writing a segment register makes its base equal to the written value shifted left by four bits. The next accepted request uses the new base.
- R3: The low-byte physical address is base plus offset, truncated to 20 bits.
- R4: The segment select encoding is 0 for ES, 1 for CS, 2 for SS and 3 for DS, on both the register write port and the request port.
- R5: A byte access uses exactly one memory cycle. A byte read returns the byte on rdata[7:0] with rdata[15:8] equal to 0.
- R6: A word access that is not split uses two consecutive memory cycles. The first is at address A and carries the low byte. The second is at A+1 and carries the high byte.
- R7: A word access at offset 0xFFFF takes its high byte from the segment base itself, which is offset 0 of the same segment.
- R8: A word whose low byte is at physical 0xFFFFF takes its high byte from physical 0x00000.
- R9: The request kind encoding is 0 for read, 1 for write, 2 for read-modify-write and 3 for read. A read-modify-write proceeds as follows:
  - It reads all bytes of the access.
  - It then holds mod_req high with the old value stable on rdata until mod_valid arrives.
  - It then writes mod_data to the same addresses, in the same order.
- R10: busy rises in the cycle after a request is accepted. done pulses for one cycle, in the cycle after the last memory cycle. Requests presented while busy are ignored.
- R11: mem_we is high only during memory cycles of write or write-back phases. Write data goes out low byte first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seg_wr | input | 1 | Segment register write strobe |
| seg_wr_sel | input | 2 | Segment register to write |
| seg_wr_val | input | 16 | New segment register value |
| req_valid | input | 1 | Access request, taken when idle |
| req_seg | input | 2 | Segment used by the request |
| req_off | input | 16 | Offset within the segment |
| req_word | input | 1 | 1 for word, 0 for byte |
| req_kind | input | 2 | Read, write or read-modify-write |
| req_wdata | input | 16 | Write data for plain writes |
| mod_valid | input | 1 | Modified value is ready |
| mod_data | input | 16 | Modified value for write-back |
| mod_req | output | 1 | Old value is on rdata; waiting for the modified value |
| rdata | output | 16 | Assembled read value |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion strobe |
| mem_en | output | 1 | Memory cycle active |
| mem_we | output | 1 | Memory cycle is a write |
| mem_addr | output | 20 | Physical byte address |
| mem_wdata | output | 8 | Byte written to memory |
| mem_rdata | input | 8 | Byte read from memory in the same cycle |

## Verification
The hardest case to reach is the one where both wrap conditions hold at once. This happens when offset 0xFFFF lands the low byte on a physical address that also wraps past the top of memory, and it is combined with a read-modify-write that has to reuse the two scattered addresses. The stimulus reaches this case as follows:
- It loads a segment base of 0xFFFF0 into SS, so offset 0x000F hits physical 0xFFFFF.
- It uses CS from reset, where offset 0xFFFF truncates past 20 bits.
- It runs reads, writes and read-modify-write accesses through each of those segments.

A behavioural memory returns a pattern computed from each address. Every memory cycle is logged, so any misplaced high byte shows up as a wrong address or a wrong assembled value.

// File: rtl/seg_pkg.sv
package seg_pkg;

    localparam int PHYS_W = 20;
    localparam int OFF_W  = 16;
    localparam int SEG_W  = 16;
    localparam int NSEG   = 4;
    localparam int SEL_W  = $clog2(NSEG);

    typedef enum logic [1:0] {
        SEG_ES = 2'd0,
        SEG_CS = 2'd1,
        SEG_SS = 2'd2,
        SEG_DS = 2'd3
    } seg_id_t;

    typedef enum logic [1:0] {
        ACC_RD   = 2'd0,
        ACC_WR   = 2'd1,
        ACC_RMW  = 2'd2,
        ACC_RD2  = 2'd3
    } acc_kind_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_LO,
        ST_RD_HI,
        ST_MOD,
        ST_WR_LO,
        ST_WR_HI,
        ST_FIN
    } seq_state_t;

    typedef struct packed {
        logic [PHYS_W-1:0] lo;
        logic [PHYS_W-1:0] hi;
    } addr_pair_t;

    function automatic logic is_write_state(seq_state_t s);
        return (s == ST_WR_LO) || (s == ST_WR_HI);
    endfunction

    function automatic logic is_mem_state(seq_state_t s);
        return (s == ST_RD_LO) || (s == ST_RD_HI) || is_write_state(s);
    endfunction

endpackage

// File: rtl/seg_base_file.sv
module seg_base_file
    import seg_pkg::*;
#(
    parameter int N      = NSEG,
    parameter int SW     = SEG_W,
    parameter int PW     = PHYS_W,
    parameter int RST_HI = int'(SEG_CS)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr,
    input  logic [$clog2(N)-1:0]      wr_sel,
    input  logic [SW-1:0]             wr_val,
    output logic [N-1:0][PW-1:0]      bases
);
    localparam int SH = PW - SW;

    for (genvar i = 0; i < N; i++) begin : g_seg
        localparam logic [PW-1:0] RST_VAL =
            (i == RST_HI) ? {{SW{1'b1}}, {SH{1'b0}}} : '0;

        always_ff @(posedge clk) begin
            if (rst) begin
                bases[i] <= RST_VAL;
            end else if (wr && (wr_sel == i[$clog2(N)-1:0])) begin
                bases[i] <= {wr_val, {SH{1'b0}}};
            end
        end
    end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_pkg::*;
#(
    parameter int N  = NSEG,
    parameter int PW = PHYS_W,
    parameter int OW = OFF_W
) (
    input  logic [N-1:0][PW-1:0]  bases,
    input  logic [$clog2(N)-1:0]  sel,
    input  logic [OW-1:0]         off,
    output addr_pair_t            pair
);
    logic [PW-1:0] base_s;
    logic [PW-1:0] lo_a;

    always_comb begin
        base_s  = bases[sel];
        lo_a    = base_s + {{(PW-OW){1'b0}}, off};
        pair.lo = lo_a;
        // Offset wrap keeps the high byte inside the segment; otherwise the
        // increment wraps naturally at the top of the physical space.
        pair.hi = (&off) ? base_s : lo_a + 1'b1;
    end
endmodule

// File: rtl/seg_byte_seq.sv
module seg_byte_seq
    import seg_pkg::*;
#(
    parameter int PW = PHYS_W,
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  addr_pair_t      pair_i,
    input  logic            word_i,
    input  acc_kind_t       kind_i,
    input  logic [DW-1:0]   wdata_i,
    input  logic            mod_valid,
    input  logic [DW-1:0]   mod_data,
    input  logic [7:0]      mem_rdata,
    output logic            mem_en,
    output logic            mem_we,
    output logic [PW-1:0]   mem_addr,
    output logic [7:0]      mem_wdata,
    output logic            mod_req,
    output logic [DW-1:0]   rdata,
    output logic            busy,
    output logic            done
);
    seq_state_t    st_q, st_d;
    addr_pair_t    pair_q;
    logic          word_q;
    acc_kind_t     kind_q;
    logic [DW-1:0] wbuf_q;
    logic [DW-1:0] rbuf_q;
    seq_state_t    after_rd;

    always_comb begin
        after_rd = (kind_q == ACC_RMW) ? ST_MOD : ST_FIN;
        st_d     = st_q;
        unique case (st_q)
            ST_IDLE:  if (start) st_d = (kind_i == ACC_WR) ? ST_WR_LO : ST_RD_LO;
            ST_RD_LO: st_d = word_q ? ST_RD_HI : after_rd;
            ST_RD_HI: st_d = after_rd;
            ST_MOD:   if (mod_valid) st_d = ST_WR_LO;
            ST_WR_LO: st_d = word_q ? ST_WR_HI : ST_FIN;
            ST_WR_HI: st_d = ST_FIN;
            ST_FIN:   st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            pair_q <= '0;
            word_q <= 1'b0;
            kind_q <= ACC_RD;
            wbuf_q <= '0;
            rbuf_q <= '0;
        end else begin
            st_q <= st_d;
            unique case (st_q)
                ST_IDLE: if (start) begin
                    pair_q <= pair_i;
                    word_q <= word_i;
                    kind_q <= kind_i;
                    wbuf_q <= wdata_i;
                    rbuf_q <= '0;
                end
                ST_RD_LO: rbuf_q[7:0]  <= mem_rdata;
                ST_RD_HI: rbuf_q[15:8] <= mem_rdata;
                ST_MOD:   if (mod_valid) wbuf_q <= mod_data;
                default: ;
            endcase
        end
    end

    always_comb begin
        mem_en    = is_mem_state(st_q);
        mem_we    = is_write_state(st_q);
        mem_addr  = ((st_q == ST_RD_HI) || (st_q == ST_WR_HI)) ? pair_q.hi : pair_q.lo;
        mem_wdata = (st_q == ST_WR_HI) ? wbuf_q[15:8] : wbuf_q[7:0];
        mod_req   = (st_q == ST_MOD);
        busy      = (st_q != ST_IDLE);
        done      = (st_q == ST_FIN);
        rdata     = rbuf_q;
    end
endmodule

// File: rtl/seg_word_mover.sv
module seg_word_mover
    import seg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                seg_wr,
    input  logic [SEL_W-1:0]    seg_wr_sel,
    input  logic [SEG_W-1:0]    seg_wr_val,
    input  logic                req_valid,
    input  logic [SEL_W-1:0]    req_seg,
    input  logic [OFF_W-1:0]    req_off,
    input  logic                req_word,
    input  logic [1:0]          req_kind,
    input  logic [15:0]         req_wdata,
    input  logic                mod_valid,
    input  logic [15:0]         mod_data,
    output logic                mod_req,
    output logic [15:0]         rdata,
    output logic                busy,
    output logic                done,
    output logic                mem_en,
    output logic                mem_we,
    output logic [PHYS_W-1:0]   mem_addr,
    output logic [7:0]          mem_wdata,
    input  logic [7:0]          mem_rdata
);
    logic [NSEG-1:0][PHYS_W-1:0] bases;
    addr_pair_t                  pair;

    seg_base_file #(.N(NSEG), .SW(SEG_W), .PW(PHYS_W), .RST_HI(int'(SEG_CS))) u_bases (
        .clk    (clk),
        .rst    (rst),
        .wr     (seg_wr),
        .wr_sel (seg_wr_sel),
        .wr_val (seg_wr_val),
        .bases  (bases)
    );

    seg_addr_gen #(.N(NSEG), .PW(PHYS_W), .OW(OFF_W)) u_agen (
        .bases (bases),
        .sel   (req_seg),
        .off   (req_off),
        .pair  (pair)
    );

    seg_byte_seq #(.PW(PHYS_W), .DW(16)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (req_valid),
        .pair_i    (pair),
        .word_i    (req_word),
        .kind_i    (acc_kind_t'(req_kind)),
        .wdata_i   (req_wdata),
        .mod_valid (mod_valid),
        .mod_data  (mod_data),
        .mem_rdata (mem_rdata),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mod_req   (mod_req),
        .rdata     (rdata),
        .busy      (busy),
        .done      (done)
    );
endmodule

// File: rtl/seg_word_mover_chk.sv
module seg_word_mover_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        done,
    input logic        mem_en,
    input logic        mem_we,
    input logic        req_valid,
    input logic        req_word,
    input logic [1:0]  req_kind,
    input logic        mod_req,
    input logic        mod_valid,
    input logic [15:0] rdata
);
    p_we_in_cycle_r11: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_en);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_after_mem_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(mem_en));

    p_accept_busy_r10: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_valid) |=> busy);

    p_byte_once_r5: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_valid && !req_word && req_kind != 2'd2) |=> mem_en ##1 done);

    p_mod_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (mod_req && !mod_valid) |=> (mod_req && $stable(rdata)));
endmodule

bind seg_word_mover seg_word_mover_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .done      (done),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .req_valid (req_valid),
    .req_word  (req_word),
    .req_kind  (req_kind),
    .mod_req   (mod_req),
    .mod_valid (mod_valid),
    .rdata     (rdata)
);

// File: tb/seg_word_mover_test.sv
module seg_word_mover_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        seg_wr = 1'b0;
    logic [1:0]  seg_wr_sel = '0;
    logic [15:0] seg_wr_val = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_seg = '0;
    logic [15:0] req_off = '0;
    logic        req_word = 1'b0;
    logic [1:0]  req_kind = '0;
    logic [15:0] req_wdata = '0;
    logic        mod_valid = 1'b0;
    logic [15:0] mod_data = '0;
    logic        mod_req, busy, done, mem_en, mem_we;
    logic [15:0] rdata;
    logic [19:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;

    always #2 clk = ~clk;

    function automatic logic [7:0] pat(input logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {4'h5, a[19:16]};
    endfunction

    assign mem_rdata = pat(mem_addr);

    seg_word_mover uut (.*);

    int n_chk = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // memory cycle log, taken away from the active edge
    logic [19:0] lg_a [8];
    logic        lg_w [8];
    logic [7:0]  lg_d [8];
    int          nlog = 0;

    always @(negedge clk) begin
        if (!rst && mem_en) begin
            if (nlog < 8) begin
                lg_a[nlog] = mem_addr;
                lg_w[nlog] = mem_we;
                lg_d[nlog] = mem_wdata;
            end
            nlog++;
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    logic [19:0] bb [4];   // bench model of bases: 0 ES, 1 CS, 2 SS, 3 DS

    task automatic segw(input logic [1:0] sel, input logic [15:0] val);
        @(negedge clk);
        seg_wr = 1'b1; seg_wr_sel = sel; seg_wr_val = val;
        @(negedge clk);
        seg_wr = 1'b0;
        bb[sel] = {val, 4'h0};
    endtask

    task automatic run(input string req, input logic [1:0] sel, input logic [15:0] off,
                       input logic word, input logic [1:0] kind,
                       input logic [15:0] wd, input logic [15:0] md, input bit nag);
        logic [19:0] a0, a1;
        logic [19:0] ea [8];
        logic        ew [8];
        logic [7:0]  ed [8];
        int          ne;
        logic [15:0] old_v;
        int          guard;
        bit          ok;
        a0 = bb[sel] + {4'h0, off};
        a1 = (off == 16'hFFFF) ? bb[sel] : a0 + 20'd1;
        old_v = word ? {pat(a1), pat(a0)} : {8'h00, pat(a0)};
        ne = 0;
        if (kind != 2'd1) begin
            ea[ne] = a0; ew[ne] = 1'b0; ed[ne] = 8'h0; ne++;
            if (word) begin ea[ne] = a1; ew[ne] = 1'b0; ed[ne] = 8'h0; ne++; end
        end
        if (kind == 2'd1 || kind == 2'd2) begin
            logic [15:0] v;
            v = (kind == 2'd2) ? md : wd;
            ea[ne] = a0; ew[ne] = 1'b1; ed[ne] = v[7:0]; ne++;
            if (word) begin ea[ne] = a1; ew[ne] = 1'b1; ed[ne] = v[15:8]; ne++; end
        end
        @(negedge clk);
        nlog = 0;
        req_valid = 1'b1; req_seg = sel; req_off = off; req_word = word;
        req_kind = kind; req_wdata = wd;
        @(negedge clk);
        if (nag) begin
            req_off = off ^ 16'h0500; req_kind = 2'd1; req_seg = sel + 2'd1;
            @(negedge clk);
        end
        req_valid = 1'b0;
        guard = 0;
        while (!done && guard < 40) begin
            if (mod_req) begin
                check(rdata == old_v, req, "old value at modify", {16'h0, rdata}, {16'h0, old_v});
                mod_valid = 1'b1; mod_data = md;
                @(negedge clk);
                mod_valid = 1'b0;
            end else begin
                @(negedge clk);
            end
            guard++;
        end
        check(done == 1'b1, req, "done seen", {31'h0, done}, 32'h1);
        if (kind != 2'd1)
            check(rdata == old_v, req, "read value", {16'h0, rdata}, {16'h0, old_v});
        repeat (3) @(negedge clk);
        check(!busy, req, "idle after done", {31'h0, busy}, 32'h0);
        ok = (nlog == ne);
        for (int i = 0; i < ne && i < 8; i++)
            if (lg_a[i] != ea[i] || lg_w[i] != ew[i] || (ew[i] && lg_d[i] != ed[i])) ok = 0;
        check(ok, req, "memory cycle count", nlog, ne);
        for (int i = 0; i < ne && i < nlog && i < 8; i++)
            if (lg_a[i] != ea[i] || lg_w[i] != ew[i] || (ew[i] && lg_d[i] != ed[i]))
                $display("  cycle %0d: addr %h we %b data %h, expected %h %b %h",
                         i, lg_a[i], lg_w[i], lg_d[i], ea[i], ew[i], ed[i]);
    endtask

    // vector: {sel[1:0], off[15:0], word, kind[1:0]}
    localparam logic [20:0] VEC [11] = '{
        {2'd1, 16'h0000, 1'b1, 2'd0},  // R1 CS word read at reset base
        {2'd0, 16'h0010, 1'b0, 2'd0},  // R5 byte read, R4 ES
        {2'd0, 16'hFFFF, 1'b1, 2'd0},  // R7 offset wrap
        {2'd2, 16'h000F, 1'b1, 2'd0},  // R8 physical wrap
        {2'd3, 16'h0005, 1'b1, 2'd1},  // R6 R11 word write
        {2'd0, 16'hFFFF, 1'b1, 2'd1},  // R7 split write
        {2'd2, 16'h000F, 1'b1, 2'd2},  // R9 R8 split rmw
        {2'd3, 16'hFFFF, 1'b0, 2'd2},  // R9 byte rmw
        {2'd1, 16'h1000, 1'b0, 2'd1},  // R5 byte write
        {2'd2, 16'h0010, 1'b1, 2'd3},  // R3 truncation, kind 3 reads
        {2'd1, 16'hFFFF, 1'b1, 2'd2}   // R7 R3 R9 both wraps
    };

    function automatic string vtag(input int i);
        case (i)
            0: return "R1";
            1: return "R5";
            2: return "R7";
            3: return "R8";
            4: return "R6";
            5: return "R7";
            6: return "R9";
            7: return "R9";
            8: return "R5";
            9: return "R3";
            default: return "R7";
        endcase
    endfunction

    initial begin
        bb[0] = 20'h0; bb[1] = 20'hFFFF0; bb[2] = 20'h0; bb[3] = 20'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(!busy && !done, "R10", "reset busy/done", {30'h0, busy, done}, 32'h0);
        check(!mem_en && !mod_req, "R10", "reset mem_en/mod_req", {30'h0, mem_en, mod_req}, 32'h0);

        // R1 first access from reset CS base
        run("R1", 2'd1, 16'h0000, 1'b1, 2'd0, 16'h0, 16'h0, 1'b0);

        // R4 segment setup through the write port
        segw(2'd0, 16'h1234);
        segw(2'd2, 16'hFFFF);
        segw(2'd3, 16'h0100);

        for (int i = 0; i < 11; i++) begin
            logic [20:0] v;
            v = VEC[i];
            run(vtag(i), v[20:19], v[18:3], v[2], v[1:0],
                v[18:3] ^ 16'hC3A5, ~v[18:3], 1'b0);
        end

        // R2 rewrite a base and use it at once
        segw(2'd3, 16'hABCD);
        run("R2", 2'd3, 16'h0003, 1'b0, 2'd0, 16'h0, 16'h0, 1'b0);
        run("R2", 2'd3, 16'h0FFE, 1'b1, 2'd0, 16'h0, 16'h0, 1'b0);

        // R10 request held and altered while busy is ignored
        run("R10", 2'd0, 16'h0020, 1'b1, 2'd0, 16'h0, 16'h0, 1'b1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule